// File: doc/BRIEF.md
# Indexed-Register Priority Interrupt Controller

This block is a core-local interrupt controller. It samples a vector of level-sensitive request inputs, keeps a 4-bit urgency value and an enable bit for each line, and raises a single interrupt output. That output carries the number of the most urgent line that is pending and enabled. The line is signalled only when a global enable is set and the line's urgency passes a threshold. Line numbers begin at 16, because numbers 0 to 15 belong to exceptions. The first group of lines is classed as private to the core, and the lines above that group are common sources.

Software never sees a flat per-line register map. It writes a line number into a select register, and the urgency and enable registers then read or write that one line only. A status register holds the global enable and the threshold. A read-only configuration word describes how the block was built, so that software can size its setup loops.

Top module: `prio_irq_ctrl`

## Requirements
- R1: External line k (0-based bit of `req_i`) has line number 16+k. When `irq_o` is high, `irq_line_o` holds that number, which lies in 16 .. 16+NUM_LINES-1. When `irq_o` is low, `irq_line_o` is 0.
- R2: Register addresses are select=0, urgency=1, enable=2, status=3, config=4. A write to urgency (wdata[3:0]) or enable (wdata[0]) changes only the line whose number is held in select. A read returns that line's value, zero-extended.
- R3: When select holds a number outside 16 .. 16+NUM_LINES-1, urgency and enable writes change no line, and urgency and enable reads return 0. Select itself reads back the 8-bit value written.
- R4: After reset, every line's enable is 1, every urgency is 0, status reads 0 and `irq_o` is 0.
- R5: The config register reads version in [7:0], NUM_LINES in [15:8], NUM_LINES-PRIVATE_LINES in [23:16], NUM_PRIO-1 in [27:24] and the fast-interrupt flag in [28]. Bits [31:29] read 0. Writes to it have no effect.
- R6: Status bit 0 is the global enable. While it is 0, `irq_o` stays low.
- R7: Status bits [4:1] hold the threshold. A line qualifies only if its urgency is less than or equal to the threshold. Level 0 is the most urgent.
- R8: Among the pending, enabled lines, the one with the lowest urgency value wins. When urgency values are equal, the lower line number wins.
- R9: Requests are level-sensitive. A request raised at one clock edge can be signalled on `irq_o` two edges later. When the request is removed, the line stops being signalled after the same delay.
- R10: A line whose enable is 0 is never signalled, even if its request is high.
- R11: `irq_private_o` is 1 with `irq_o` when the signalled line number is below 16+PRIVATE_LINES, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_LINES | Level-sensitive request per line (bit k is line 16+k) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Interrupt request to the core |
| irq_line_o | output | 8 | Number of the signalled line |
| irq_private_o | output | 1 | Signalled line is a private per-core source |

## Verification
On every cycle, the assertions check the gating of the output. The interrupt may only follow a set global enable, a passing threshold, a request that was present two cycles earlier, and a legal line number. They also check that the internal winner is enabled and pending, that no candidate beats it on urgency, and that reads through an out-of-range select return zero. Other behaviours only show up in the bench's scenarios: the reset contents of the line table, the confinement of window writes to the selected line, tie-breaking by line number, and the exact layout of the configuration word.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int EXC_LINES = 16;

  typedef enum logic [2:0] {
    RA_SELECT = 3'd0,
    RA_PRIO   = 3'd1,
    RA_ENABLE = 3'd2,
    RA_STATUS = 3'd3,
    RA_CONFIG = 3'd4
  } reg_addr_e;

  function automatic logic [31:0] build_cfg(input int ver, input int lines,
                                            input int priv, input int levels,
                                            input bit fast);
    logic [31:0] w;
    w        = 32'h0;
    w[7:0]   = 8'(ver);
    w[15:8]  = 8'(lines);
    w[23:16] = 8'(lines - priv);
    w[27:24] = 4'(levels - 1);
    w[28]    = fast;
    return w;
  endfunction

  function automatic logic prio_passes(input logic [3:0] p, input logic [3:0] thr);
    return p <= thr;
  endfunction

endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
  parameter int NUM_LINES = 16,
  parameter int PRIO_W    = 4,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sel_ok,
  input  logic [IDX_W-1:0]                  sel_idx,
  input  logic                              wr_prio,
  input  logic                              wr_en,
  input  logic [PRIO_W-1:0]                 prio_wdata,
  input  logic                              en_wdata,
  output logic [NUM_LINES-1:0][PRIO_W-1:0]  prio_o,
  output logic [NUM_LINES-1:0]              en_o
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit;
    assign hit = sel_ok && (sel_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_o[i] <= '0;
        en_o[i]   <= 1'b1;
      end else begin
        if (wr_prio && hit) prio_o[i] <= prio_wdata;
        if (wr_en && hit)   en_o[i]   <= en_wdata;
      end
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_LINES = 16,
  parameter int PRIO_W    = 4,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]              cand_i,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0]  prio_i,
  output logic                              win_valid_o,
  output logic [IDX_W-1:0]                  win_idx_o,
  output logic [PRIO_W-1:0]                 win_prio_o
);

  // Scan from the top index down; "<=" lets a lower index take an equal urgency.
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_prio_o  = '1;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand_i[i] && (!win_valid_o || prio_i[i] <= win_prio_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_prio_o  = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int  NUM_LINES     = 16,
  parameter int  PRIVATE_LINES = 8,
  parameter int  NUM_PRIO      = 16,
  parameter int  VERSION       = 2,
  parameter bit  FAST_IRQ      = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  req_i,
  input  logic                  reg_wr_i,
  input  logic [2:0]            reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  output logic                  irq_o,
  output logic [7:0]            irq_line_o,
  output logic                  irq_private_o
);

  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int PRIO_W    = $clog2(NUM_PRIO);
  localparam int LAST_LINE = EXC_LINES + NUM_LINES - 1;
  localparam logic [31:0] CFG_WORD =
    build_cfg(VERSION, NUM_LINES, PRIVATE_LINES, NUM_PRIO, FAST_IRQ);

  // Register state
  logic [7:0]            sel_q;
  logic                  gie_q;
  logic [PRIO_W-1:0]     thr_q;
  logic [NUM_LINES-1:0]  pend_q;

  // Named internal events (observed by the checker)
  logic                             sel_in_range;
  logic [IDX_W-1:0]                 sel_idx;
  logic                             wr_sel, wr_prio, wr_en, wr_status;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_vec;
  logic [NUM_LINES-1:0]             en_vec;
  logic [NUM_LINES-1:0]             cand;
  logic                             win_valid;
  logic [IDX_W-1:0]                 win_idx;
  logic [PRIO_W-1:0]                win_prio;
  logic                             irq_d;

  assign sel_in_range = (32'(sel_q) >= EXC_LINES) && (32'(sel_q) <= LAST_LINE);
  assign sel_idx      = IDX_W'(sel_q - 8'(EXC_LINES));

  assign wr_sel    = reg_wr_i && (reg_addr_i == RA_SELECT);
  assign wr_prio   = reg_wr_i && (reg_addr_i == RA_PRIO);
  assign wr_en     = reg_wr_i && (reg_addr_i == RA_ENABLE);
  assign wr_status = reg_wr_i && (reg_addr_i == RA_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      gie_q  <= 1'b0;
      thr_q  <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= req_i;
      if (wr_sel) sel_q <= reg_wdata_i[7:0];
      if (wr_status) begin
        gie_q <= reg_wdata_i[0];
        thr_q <= reg_wdata_i[PRIO_W:1];
      end
    end
  end

  irq_line_bank #(
    .NUM_LINES(NUM_LINES),
    .PRIO_W   (PRIO_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_ok    (sel_in_range),
    .sel_idx   (sel_idx),
    .wr_prio   (wr_prio),
    .wr_en     (wr_en),
    .prio_wdata(reg_wdata_i[PRIO_W-1:0]),
    .en_wdata  (reg_wdata_i[0]),
    .prio_o    (prio_vec),
    .en_o      (en_vec)
  );

  assign cand = pend_q & en_vec;

  irq_arbiter #(
    .NUM_LINES(NUM_LINES),
    .PRIO_W   (PRIO_W)
  ) u_arb (
    .cand_i     (cand),
    .prio_i     (prio_vec),
    .win_valid_o(win_valid),
    .win_idx_o  (win_idx),
    .win_prio_o (win_prio)
  );

  assign irq_d = win_valid && gie_q && prio_passes(4'(win_prio), 4'(thr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o         <= 1'b0;
      irq_line_o    <= '0;
      irq_private_o <= 1'b0;
    end else begin
      irq_o         <= irq_d;
      irq_line_o    <= irq_d ? 8'(EXC_LINES) + 8'(win_idx) : 8'h00;
      irq_private_o <= irq_d && (32'(win_idx) < PRIVATE_LINES);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_SELECT: reg_rdata_o = {24'h0, sel_q};
      RA_PRIO:   if (sel_in_range) reg_rdata_o = 32'(prio_vec[sel_idx]);
      RA_ENABLE: if (sel_in_range) reg_rdata_o = 32'(en_vec[sel_idx]);
      RA_STATUS: reg_rdata_o = 32'({thr_q, gie_q});
      RA_CONFIG: reg_rdata_o = CFG_WORD;
      default:   reg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_LINES = 16,
  parameter int PRIO_W    = 4,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_LINES-1:0]             req_i,
  input logic [2:0]                       reg_addr_i,
  input logic [31:0]                      reg_rdata_o,
  input logic                             irq_o,
  input logic [7:0]                       irq_line_o,
  input logic                             gie_q,
  input logic [PRIO_W-1:0]                thr_q,
  input logic [NUM_LINES-1:0]             pend_q,
  input logic [NUM_LINES-1:0]             en_vec,
  input logic [NUM_LINES-1:0][PRIO_W-1:0] prio_vec,
  input logic                             sel_in_range,
  input logic                             win_valid,
  input logic [IDX_W-1:0]                 win_idx,
  input logic [PRIO_W-1:0]                win_prio
);

  logic better_exists;
  logic req_seen;
  logic [NUM_LINES-1:0] req_d1, req_d2;

  always_comb begin
    better_exists = 1'b0;
    for (int i = 0; i < NUM_LINES; i++)
      if (pend_q[i] && en_vec[i] && prio_vec[i] < win_prio) better_exists = 1'b1;
  end

  always_ff @(posedge clk) begin
    req_d1 <= req_i;
    req_d2 <= req_d1;
  end

  assign req_seen = req_d2[irq_line_o[IDX_W-1:0]];

  // R6
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(gie_q));

  // R7
  thr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(win_prio <= thr_q));

  // R10
  win_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (en_vec[win_idx] && pend_q[win_idx]));

  // R8
  win_urgent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> !better_exists);

  // R3
  oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_in_range && (reg_addr_i == 3'd1 || reg_addr_i == 3'd2)) |-> (reg_rdata_o == 32'h0));

  // R1
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_line_o >= 8'd16 && 32'(irq_line_o) < 16 + NUM_LINES));

  // R9
  level_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(rst_n, 2)) |-> req_seen);

endmodule

bind prio_irq_ctrl prio_irq_chk #(
  .NUM_LINES(NUM_LINES),
  .PRIO_W   (PRIO_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .irq_line_o  (irq_line_o),
  .gie_q       (gie_q),
  .thr_q       (thr_q),
  .pend_q      (pend_q),
  .en_vec      (en_vec),
  .prio_vec    (prio_vec),
  .sel_in_range(sel_in_range),
  .win_valid   (win_valid),
  .win_idx     (win_idx),
  .win_prio    (win_prio)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

  localparam int N     = 16;
  localparam int BASE  = 16;
  localparam int PRIV  = 8;
  localparam int LVLS  = 16;
  localparam int VER   = 2;
  localparam int WATCHDOG = 20000;

  localparam logic [2:0] A_SEL = 3'd0, A_PRI = 3'd1, A_EN = 3'd2, A_ST = 3'd3, A_CFG = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          wr = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  logic [7:0]    line;
  logic          priv;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    bit         v;
    logic [7:0] line;
    bit         priv;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;

  prio_irq_ctrl #(.NUM_LINES(N), .PRIVATE_LINES(PRIV), .NUM_PRIO(LVLS), .VERSION(VER)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .irq_line_o(line),
    .irq_private_o(priv)
  );

  // Monitor: pops expected items and compares against the outputs
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (irq !== e.v || line !== e.line || priv !== e.priv) begin
        n_fail++;
        $display("FAIL %s: irq/line/priv = %0b/%0d/%0b, expected %0b/%0d/%0b",
                 e.tag, irq, line, priv, e.v, e.line, e.priv);
      end
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; wr = 1'b0;
    #1;
    n_checks++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata = %08h, expected %08h", tag, rdata, exp);
    end
  endtask

  // Driver: lets the two-register pipeline settle, then pushes the expected item
  task automatic expect_irq(input bit v, input int ln, input string tag);
    exp_t e;
    repeat (3) @(posedge clk);
    e.v    = v;
    e.line = v ? 8'(ln) : 8'h00;
    e.priv = v && (ln < BASE + PRIV);
    e.tag  = tag;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  function automatic logic [31:0] status_word(input bit g, input int thr);
    return 32'(thr) * 2 + 32'(g);
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] cfg_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 reset state
    expect_irq(0, 0, "R4 irq low after reset");
    reg_check(A_ST, 32'h0, "R4 status zero");
    for (int k = 0; k < N; k++) begin
      reg_write(A_SEL, 32'(BASE + k));
      reg_check(A_EN, 32'h1, "R4 enable reset to 1");
      reg_check(A_PRI, 32'h0, "R4 urgency reset to 0");
    end

    // R5 configuration word, write has no effect
    cfg_exp = {3'b000, 1'b0, 4'(LVLS - 1), 8'(N - PRIV), 8'(N), 8'(VER)};
    reg_check(A_CFG, cfg_exp, "R5 config layout");
    reg_write(A_CFG, 32'hFFFF_FFFF);
    reg_check(A_CFG, cfg_exp, "R5 config read-only");

    // R6 global enable off: request present but nothing signalled
    req[3] = 1'b1;
    expect_irq(0, 0, "R6 gie clear blocks");

    // R1/R9/R11 gie on, threshold 0
    reg_write(A_ST, status_word(1, 0));
    expect_irq(1, BASE + 3, "R1 R11 line 19 signalled private");

    // R8 tie at urgency 0: lower number wins
    req[10] = 1'b1;
    expect_irq(1, BASE + 3, "R8 tie lower line wins");

    // R2 program line 19 urgency 5, threshold 15 -> line 26 now more urgent
    reg_write(A_ST, status_word(1, 15));
    reg_write(A_SEL, 32'(BASE + 3));
    reg_write(A_PRI, 32'd5);
    reg_check(A_PRI, 32'd5, "R2 selected line urgency readback");
    reg_write(A_SEL, 32'(BASE + 10));
    reg_check(A_PRI, 32'd0, "R2 other line untouched");
    reg_check(A_SEL, 32'(BASE + 10), "R3 select readback");
    expect_irq(1, BASE + 10, "R8 lower urgency value wins, R11 common");

    // R7 threshold
    reg_write(A_PRI, 32'd6);
    reg_write(A_ST, status_word(1, 4));
    expect_irq(0, 0, "R7 both above threshold");
    reg_write(A_ST, status_word(1, 5));
    expect_irq(1, BASE + 3, "R7 equal to threshold passes");

    // R10 disable line 19
    reg_write(A_SEL, 32'(BASE + 3));
    reg_write(A_EN, 32'd0);
    reg_check(A_EN, 32'd0, "R2 enable readback");
    expect_irq(0, 0, "R10 disabled line not signalled");
    reg_write(A_ST, status_word(1, 15));
    expect_irq(1, BASE + 10, "R10 enabled line signalled instead");

    // R3 out-of-range select, high and low
    reg_write(A_SEL, 32'd40);
    reg_write(A_PRI, 32'd9);
    reg_write(A_EN, 32'd0);
    reg_check(A_PRI, 32'd0, "R3 urgency read out of range");
    reg_check(A_EN, 32'd0, "R3 enable read out of range");
    reg_write(A_SEL, 32'd5);
    reg_write(A_PRI, 32'd1);
    reg_write(A_EN, 32'd0);
    expect_irq(1, BASE + 10, "R3 out-of-range writes ignored");
    reg_write(A_SEL, 32'(BASE + 10));
    reg_check(A_PRI, 32'd6, "R3 line 26 urgency kept");
    reg_check(A_EN, 32'd1, "R3 line 26 enable kept");
    reg_write(A_SEL, 32'(BASE + N - 1));
    reg_check(A_EN, 32'd1, "R3 top line enable kept");

    // R1 top line
    req[N-1] = 1'b1;
    reg_write(A_PRI, 32'd2);
    expect_irq(1, BASE + N - 1, "R1 top line number");

    // R9 level sensitivity: drop requests
    req[N-1] = 1'b0;
    expect_irq(1, BASE + 10, "R9 dropped request no longer pending");
    req[10] = 1'b0;
    expect_irq(0, 0, "R9 all requests dropped");

    // R6 global enable clear again
    req[10] = 1'b1;
    reg_write(A_ST, status_word(0, 15));
    expect_irq(0, 0, "R6 gie cleared blocks");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule